// File: doc/BRIEF.md
# Time-Slotted Fault Status Frame Encoder

This block turns the confirmed fault state of two regulator channels into a repeating serial frame on one output wire. A companion detector confirms the faults and presents them here. Each channel has five fault flags. The detector also gives a one-cycle pulse when any fault is confirmed, and a power-good level for each channel. A one-cycle strobe, nominally once per microsecond, sets the frame timing. Each frame lasts 36 strobes. It opens with a two-strobe alert burst. The first channel's flag group comes next, then the second channel's group. Short low gaps separate these parts.

Framing begins at the first strobe after a confirm pulse. Frames repeat back to back until both power-good inputs are high again. The frame in progress always runs to its end. The flags are captured when a frame opens, so one frame always reports one consistent picture. All pins are plain control and status levels. No data stream crosses the boundary, so the block has no valid/ready handshake and no back-pressure rules. A consumer that times the line with the same strobe can decode it.

Top module: `fault_frame_enc`

## Requirements
- R1: While no frame is active, including just after reset, `fault_o` is low.
- R2: A confirm pulse starts a frame on the next strobe. A pulse that arrives in the same cycle as a strobe starts the frame on that strobe. In the cycle after the starting strobe, the frame is at tick 0.
- R3: A frame lasts 36 strobes, numbered 0 to 35. Ticks 0 and 1 are the alert and are always high. Ticks 2-3, 18-19 and 34-35 are always low.
- R4: Channel 1 occupies ticks 4 to 17 and channel 2 occupies ticks 20 to 33. Within a group, the slots by offset are: high over-voltage at 0, low over-voltage at 1, under-voltage at 2-5, over-temperature at 6-9 and over-current at 10-13.
- R5: Each flag input is encoded as bit 4 high over-voltage, bit 3 low over-voltage, bit 2 under-voltage, bit 1 over-temperature and bit 0 over-current. A slot is high exactly when its bit is 1.
- R6: The flags are captured at the strobe that opens a frame. Changes during the frame have no effect until the next frame.
- R7: At the end of a frame, a new frame starts on the same strobe if either power-good input is low.
- R8: Power-good returning mid-frame does not cut the frame short. With both power-good inputs high and no pending confirm, the line goes idle at the frame end.
- R9: A confirm pulse during a frame does not restart the frame. It is remembered and forces one more frame after the current one, even with power good.
- R10: The output and the frame position change only on the cycle after a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle timing strobe, one per frame tick |
| fault_confirm_i | input | 1 | One-cycle pulse: a fault was confirmed |
| ch1_flags_i | input | 5 | Channel 1 flags, encoded as in R5 |
| ch2_flags_i | input | 5 | Channel 2 flags, encoded as in R5 |
| pgood_i | input | 2 | Power-good level per channel (bit 0 is channel 1) |
| fault_o | output | 1 | Serial fault frame line |

## Verification
Each result appears one clock after the strobe that causes it. This covers the alert after a starting strobe, every slot transition, the idle fall at the frame end, and the captured flags. Flag or power-good changes between strobes show up only at the next strobe. The bench keeps a behavioural frame model with tick counter, pending flag and captured flags. The model advances on the same rising edge as the design. It is compared with the line at every falling edge, so any slip of even one cycle is reported. Inputs are driven shortly after the falling edge, and the strobe-aligned confirm case is placed by observing the strobe itself.

// File: rtl/fault_frame_pkg.sv
package fault_frame_pkg;
  localparam int unsigned NUM_FLAGS = 5;
  localparam int unsigned NUM_CH    = 2;

  typedef logic [NUM_FLAGS-1:0] flag_set_t;

  // bit positions within a flag set; slot order inside a group is
  // FL_OVH first down to FL_OC last
  typedef enum int unsigned {
    FL_OC  = 0,
    FL_OT  = 1,
    FL_UV  = 2,
    FL_OVL = 3,
    FL_OVH = 4
  } flag_idx_e;
endpackage

// File: rtl/ffe_frame_seq.sv
module ffe_frame_seq #(
  parameter int unsigned FRAME_LEN = 36,
  localparam int unsigned POS_W = $clog2(FRAME_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             start_req_i,
  output logic             active_o,
  output logic [POS_W-1:0] pos_o,
  output logic             load_o
);
  localparam logic [POS_W-1:0] LAST = POS_W'(FRAME_LEN - 1);

  logic at_bound;
  assign at_bound = !active_o || (pos_o == LAST);
  assign load_o   = tick_i && at_bound && start_req_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_o <= 1'b0;
      pos_o    <= '0;
    end else if (tick_i) begin
      if (!at_bound) begin
        pos_o <= pos_o + 1'b1;
      end else if (start_req_i) begin
        active_o <= 1'b1;
        pos_o    <= '0;
      end else begin
        active_o <= 1'b0;
        pos_o    <= '0;
      end
    end
  end

  p_pos_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    active_o |-> pos_o <= LAST);

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && active_o && pos_o != LAST) |=> (active_o && pos_o == $past(pos_o) + 1'b1));

  p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> ($stable(pos_o) && $stable(active_o)));

  p_finish_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && pos_o != LAST) |=> active_o);
endmodule

// File: rtl/ffe_arm.sv
module ffe_arm #(
  parameter int unsigned NUM_PG = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              confirm_i,
  input  logic              load_i,
  input  logic              active_i,
  input  logic [NUM_PG-1:0] pgood_i,
  output logic              start_req_o
);
  logic pend_q;
  logic pg_ok;

  assign pg_ok       = &pgood_i;
  assign start_req_o = pend_q || confirm_i || (active_i && !pg_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pend_q <= 1'b0;
    else if (load_i)    pend_q <= 1'b0;
    else if (confirm_i) pend_q <= 1'b1;
  end

  p_confirm_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (confirm_i && !load_i) |=> start_req_o);
endmodule

// File: rtl/ffe_slot_map.sv
module ffe_slot_map
  import fault_frame_pkg::*;
#(
  parameter int unsigned ALERT_TICKS = 2,
  parameter int unsigned GAP_TICKS   = 2,
  parameter int unsigned W_OVH       = 1,
  parameter int unsigned W_OVL       = 1,
  parameter int unsigned W_UV        = 4,
  parameter int unsigned W_OT        = 4,
  parameter int unsigned W_OC        = 4,
  parameter int unsigned POS_W       = 6
) (
  input  logic                               active_i,
  input  logic [POS_W-1:0]                   pos_i,
  input  logic [NUM_CH-1:0][NUM_FLAGS-1:0]   flags_i,
  output logic                               line_o
);
  localparam int unsigned E_OVH     = W_OVH;
  localparam int unsigned E_OVL     = E_OVH + W_OVL;
  localparam int unsigned E_UV      = E_OVL + W_UV;
  localparam int unsigned E_OT      = E_UV + W_OT;
  localparam int unsigned GROUP_LEN = E_OT + W_OC;
  localparam int unsigned G_PITCH   = GROUP_LEN + GAP_TICKS;
  localparam int unsigned G_BASE0   = ALERT_TICKS + GAP_TICKS;

  logic [NUM_CH-1:0] grp_bit;
  logic              alert_bit;

  assign alert_bit = (int'(pos_i) < int'(ALERT_TICKS));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_group
    localparam int BASE = int'(G_BASE0 + g * G_PITCH);
    always_comb begin
      int off;
      off        = int'(pos_i) - BASE;
      grp_bit[g] = 1'b0;
      if (off >= 0 && off < int'(GROUP_LEN)) begin
        if (off < int'(E_OVH))     grp_bit[g] = flags_i[g][FL_OVH];
        else if (off < int'(E_OVL)) grp_bit[g] = flags_i[g][FL_OVL];
        else if (off < int'(E_UV))  grp_bit[g] = flags_i[g][FL_UV];
        else if (off < int'(E_OT))  grp_bit[g] = flags_i[g][FL_OT];
        else                        grp_bit[g] = flags_i[g][FL_OC];
      end
    end
  end

  assign line_o = active_i && (alert_bit || (|grp_bit));
endmodule

// File: rtl/fault_frame_enc.sv
module fault_frame_enc
  import fault_frame_pkg::*;
#(
  parameter int unsigned ALERT_TICKS = 2,
  parameter int unsigned GAP_TICKS   = 2,
  parameter int unsigned W_OVH       = 1,
  parameter int unsigned W_OVL       = 1,
  parameter int unsigned W_UV        = 4,
  parameter int unsigned W_OT        = 4,
  parameter int unsigned W_OC        = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_i,
  input  logic                 fault_confirm_i,
  input  logic [NUM_FLAGS-1:0] ch1_flags_i,
  input  logic [NUM_FLAGS-1:0] ch2_flags_i,
  input  logic [NUM_CH-1:0]    pgood_i,
  output logic                 fault_o
);
  localparam int unsigned GROUP_LEN = W_OVH + W_OVL + W_UV + W_OT + W_OC;
  localparam int unsigned FRAME_LEN = ALERT_TICKS + NUM_CH * (GAP_TICKS + GROUP_LEN) + GAP_TICKS;
  localparam int unsigned POS_W     = $clog2(FRAME_LEN);

  logic                             active;
  logic [POS_W-1:0]                 pos;
  logic                             load;
  logic                             start_req;
  logic [NUM_CH-1:0][NUM_FLAGS-1:0] snap_q;

  ffe_arm #(.NUM_PG(NUM_CH)) i_arm (
    .clk(clk), .rst_n(rst_n), .confirm_i(fault_confirm_i), .load_i(load),
    .active_i(active), .pgood_i(pgood_i), .start_req_o(start_req)
  );

  ffe_frame_seq #(.FRAME_LEN(FRAME_LEN)) i_seq (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .start_req_i(start_req),
    .active_o(active), .pos_o(pos), .load_o(load)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    snap_q <= '0;
    else if (load) snap_q <= {ch2_flags_i, ch1_flags_i};
  end

  ffe_slot_map #(
    .ALERT_TICKS(ALERT_TICKS), .GAP_TICKS(GAP_TICKS), .W_OVH(W_OVH), .W_OVL(W_OVL),
    .W_UV(W_UV), .W_OT(W_OT), .W_OC(W_OC), .POS_W(POS_W)
  ) i_map (
    .active_i(active), .pos_i(pos), .flags_i(snap_q), .line_o(fault_o)
  );

  p_idle_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !fault_o);

  p_alert_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && int'(pos) < int'(ALERT_TICKS)) |-> fault_o);

  p_snap_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(snap_q));

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && fault_confirm_i && !active) |=> (active && pos == '0));
endmodule

// File: tb/test_fault_frame_enc.sv
module test_fault_frame_enc;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0;
  logic       fault_confirm_i = 1'b0;
  logic [4:0] ch1_flags_i = '0;
  logic [4:0] ch2_flags_i = '0;
  logic [1:0] pgood_i = 2'b11;
  logic       fault_o;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  int tcnt = 0;
  bit cmp_en = 1'b0;
  string tag = "R1";

  // model state
  int m_active = 0, m_pos = 0, m_pend = 0;
  logic [4:0] m_f1 = '0, m_f2 = '0;

  always #2.5 clk = ~clk;

  fault_frame_enc i_fault_frame_enc (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .fault_confirm_i(fault_confirm_i),
    .ch1_flags_i(ch1_flags_i), .ch2_flags_i(ch2_flags_i), .pgood_i(pgood_i),
    .fault_o(fault_o)
  );

  // strobe every 4 cycles
  always @(negedge clk) begin
    tcnt   = (tcnt + 1) % 4;
    tick_i <= (tcnt == 3);
  end

  function automatic logic grp(int o, logic [4:0] f);
    if (o == 0) return f[4];
    if (o == 1) return f[3];
    if (o < 6)  return f[2];
    if (o < 10) return f[1];
    return f[0];
  endfunction

  function automatic logic expect_line();
    if (m_active == 0) return 1'b0;
    if (m_pos < 2) return 1'b1;
    if (m_pos >= 4 && m_pos < 18) return grp(m_pos - 4, m_f1);
    if (m_pos >= 20 && m_pos < 34) return grp(m_pos - 20, m_f2);
    return 1'b0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_active = 0; m_pos = 0; m_pend = 0;
    end else begin
      bit start;
      start = (m_pend != 0) || fault_confirm_i || (m_active != 0 && pgood_i != 2'b11);
      if (tick_i && m_active != 0 && m_pos < 35) begin
        m_pos++;
        if (fault_confirm_i) m_pend = 1;
      end else if (tick_i && start) begin
        m_active = 1; m_pos = 0; m_pend = 0;
        m_f1 = ch1_flags_i; m_f2 = ch2_flags_i;
      end else if (tick_i) begin
        m_active = 0; m_pos = 0;
      end else if (fault_confirm_i) begin
        m_pend = 1;
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      logic e;
      e = expect_line();
      compared++;
      if (fault_o !== e) begin
        mismatched++;
        $display("FAIL %s: tick %0d fault_o=%b expected=%b", tag, m_pos, fault_o, e);
      end
    end
  end

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic pulse_confirm();
    fault_confirm_i = 1'b1;
    step(1);
    fault_confirm_i = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      mismatched++;
      $display("FAIL watchdog: run did not end, cycles=%0d expected<=%0d", cycles, 50000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    step(5);
    cmp_en = 1'b1;
    rst_n = 1'b1;
    step(1);
    // R1: reset state
    compared++;
    if (fault_o !== 1'b0) begin
      mismatched++;
      $display("FAIL R1: after reset fault_o=%b expected=0", fault_o);
    end
    step(20);

    tag = "R2 R3 R4 R5 R10";
    ch1_flags_i = 5'b10101; ch2_flags_i = 5'b01011; pgood_i = 2'b00;
    step(1);
    pulse_confirm();
    step(150);

    tag = "R6 R7";
    step(40);
    ch1_flags_i = 5'b01110; ch2_flags_i = 5'b11001;
    step(150);

    tag = "R8";
    step(30);
    pgood_i = 2'b11;
    step(300);

    tag = "R9";
    ch1_flags_i = 5'b00011; ch2_flags_i = 5'b10000;
    pulse_confirm();
    step(60);
    pulse_confirm();
    step(450);

    tag = "R2 R5";
    ch1_flags_i = 5'b11111; ch2_flags_i = 5'b00000;
    while (tick_i !== 1'b1) step(1);
    fault_confirm_i = 1'b1;
    step(1);
    fault_confirm_i = 1'b0;
    pgood_i = 2'b01;
    step(100);
    ch1_flags_i = 5'b00000; ch2_flags_i = 5'b11111;
    step(60);
    pgood_i = 2'b11;
    step(320);

    tag = "R1";
    step(20);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule